// File: doc/BRIEF.md
# Control Register Bank with Bit-Set, Bit-Clear and Bit-Toggle Aliases

This block holds a set of 32-bit control registers behind a simple valid/write/address/data request port. The byte address space is a 32 KiB window split in two halves. The lower half holds plain registers, which are written as whole words. The upper half holds aliased registers. Each aliased register spans four consecutive word slots. Slot 0 is the register itself. Slots 1, 2 and 3 are write-side views that set, clear or invert selected bits. Software can therefore change individual control bits without a read-modify-write sequence.

Every register takes its own reset value from a parameter. Aliased registers that are marked as oscillator-control registers also get a lock-status bit forced high at reset. A parameter picks the position of that bit. The block accepts only aligned word accesses inside the populated ranges. Any other access is reported on a one-cycle error flag and changes nothing. Every request gets a registered response in the following cycle.

Top module: `regbank_top`

## Requirements
- R1: After reset, plain register k reads PLAIN_RST[k]. Aliased register g reads ALIAS_RST[g], with bit LOCK_BIT (default 31) also set when PLL_MASK[g] is 1.
- R2: A write to a plain register, or to slot 0 of an aliased register, replaces all 32 bits with the write data.
- R3: A write to slot 1 (address bits [3:2] = 1) of an aliased register ORs the write data into that register.
- R4: A write to slot 2 (address bits [3:2] = 2) clears every bit of the register that is 1 in the write data.
- R5: A write to slot 3 (address bits [3:2] = 3) XORs the write data into the register.
- R6: A read of any of the four slots of an aliased register returns the register's current value and leaves it unchanged.
- R7: Address decode is as follows. Bit 14 = 0 selects the plain bank, with word index = address[13:2]. Bit 14 = 1 selects the aliased bank, with register index = address[13:4] and slot = address[3:2]. An access changes only the register it addresses.
- R8: An access with address[1:0] != 0 raises rsp_err for one cycle, returns read data zero and changes no register.
- R9: An aligned access beyond the last populated plain word or the last populated aliased register raises rsp_err, returns zero and changes no register.
- R10: rsp_valid is high exactly in the cycle after each request. rsp_rdata carries the read value there, and is zero for writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request strobe, one access per cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Byte address in the window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | 32 | Read data (zero for writes and errors) |
| rsp_err | output | 1 | Illegal access indication |

## Verification
Every register is read through every alias slot after reset. This tells the lock-bit forcing apart from the plain reset values, and shows that alias reads all map onto the same storage. Set, clear and toggle writes use overlapping bit patterns (all ones, alternating bits, walking ones) on registers whose bits are partly set. Under such patterns an OR, an AND-NOT and an XOR each give a different result. All misaligned offsets in the populated range and every out-of-range word index are swept with reads and writes. A full dump of the bank is compared against a bench model after each phase, which shows that no stray register was touched.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  localparam int unsigned DATA_W = 32;

  // Slot within an aliased register group; encoded by address bits [3:2].
  typedef enum logic [1:0] {
    SLOT_BASE = 2'd0,
    SLOT_SET  = 2'd1,
    SLOT_CLR  = 2'd2,
    SLOT_TOG  = 2'd3
  } slot_e;
endpackage

// File: rtl/regbank_decode.sv
module regbank_decode
  import regbank_pkg::*;
#(
  parameter int unsigned AW        = 15,
  parameter int unsigned NUM_PLAIN = 4,
  parameter int unsigned NUM_ALIAS = 4
) (
  input  logic                 req_valid,
  input  logic [AW-1:0]        req_addr,
  output logic [NUM_PLAIN-1:0] hit_plain,
  output logic [NUM_ALIAS-1:0] hit_alias,
  output slot_e                slot,
  output logic                 err
);
  localparam int unsigned WW = AW - 3;   // word index width within a half
  localparam int unsigned GW = WW - 2;   // group index width

  logic [WW-1:0] word;
  logic [GW-1:0] grp;
  logic          aligned;
  logic          in_alias_half;
  logic          plain_ok;
  logic          alias_ok;

  assign word          = req_addr[AW-2:2];
  assign grp           = word[WW-1:2];
  assign aligned       = (req_addr[1:0] == 2'b00);
  assign in_alias_half = req_addr[AW-1];
  assign slot          = slot_e'(word[1:0]);

  assign plain_ok = !in_alias_half && (word < WW'(NUM_PLAIN));
  assign alias_ok =  in_alias_half && (grp  < GW'(NUM_ALIAS));

  genvar gi;
  generate
    for (gi = 0; gi < NUM_PLAIN; gi++) begin : g_plain_hit
      assign hit_plain[gi] = req_valid && aligned && !in_alias_half && (word == WW'(gi));
    end
    for (gi = 0; gi < NUM_ALIAS; gi++) begin : g_alias_hit
      assign hit_alias[gi] = req_valid && aligned && in_alias_half && (grp == GW'(gi));
    end
  endgenerate

  assign err = req_valid && (!aligned || !(plain_ok || alias_ok));
endmodule

// File: rtl/regbank_cell.sv
module regbank_cell
  import regbank_pkg::*;
#(
  parameter logic [DATA_W-1:0] RST_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  slot_e             slot,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  logic [DATA_W-1:0] q_next;

  always_comb begin
    unique case (slot)
      SLOT_SET: q_next = q | wdata;
      SLOT_CLR: q_next = q & ~wdata;
      SLOT_TOG: q_next = q ^ wdata;
      default:  q_next = wdata;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= RST_VAL;
    end else if (wr_en) begin
      q <= q_next;
    end
  end
endmodule

// File: rtl/regbank_top.sv
module regbank_top
  import regbank_pkg::*;
#(
  parameter int unsigned AW        = 15,
  parameter int unsigned NUM_PLAIN = 4,
  parameter int unsigned NUM_ALIAS = 4,
  parameter int unsigned LOCK_BIT  = 31,
  parameter logic [NUM_PLAIN*DATA_W-1:0] PLAIN_RST =
    {32'h2486_0324, 32'h0001_8D00, 32'h0000_0010, 32'h0401_167F},
  parameter logic [NUM_ALIAS*DATA_W-1:0] ALIAS_RST =
    {32'h1018_101B, 32'h0001_3001, 32'h0001_2000, 32'h0001_3063},
  parameter logic [NUM_ALIAS-1:0] PLL_MASK = 4'b0111
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err
);
  localparam logic [DATA_W-1:0] LOCK_MASK = DATA_W'(1) << LOCK_BIT;

  // Reset synchronizer: asserts asynchronously, releases on a clock edge.
  logic rst_meta_n, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  logic [NUM_PLAIN-1:0] hit_plain;
  logic [NUM_ALIAS-1:0] hit_alias;
  slot_e                slot;
  logic                 dec_err;

  regbank_decode #(
    .AW(AW), .NUM_PLAIN(NUM_PLAIN), .NUM_ALIAS(NUM_ALIAS)
  ) u_decode (
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .hit_plain (hit_plain),
    .hit_alias (hit_alias),
    .slot      (slot),
    .err       (dec_err)
  );

  logic [DATA_W-1:0] plain_q [NUM_PLAIN];
  logic [DATA_W-1:0] alias_q [NUM_ALIAS];

  genvar gi;
  generate
    for (gi = 0; gi < NUM_PLAIN; gi++) begin : g_plain
      regbank_cell #(
        .RST_VAL(PLAIN_RST[gi*DATA_W +: DATA_W])
      ) u_cell (
        .clk   (clk),
        .rst_n (rst_sync_n),
        .wr_en (hit_plain[gi] && req_write),
        .slot  (SLOT_BASE),
        .wdata (req_wdata),
        .q     (plain_q[gi])
      );
    end
    for (gi = 0; gi < NUM_ALIAS; gi++) begin : g_alias
      localparam logic [DATA_W-1:0] RST_G =
        ALIAS_RST[gi*DATA_W +: DATA_W] | (PLL_MASK[gi] ? LOCK_MASK : '0);
      regbank_cell #(
        .RST_VAL(RST_G)
      ) u_cell (
        .clk   (clk),
        .rst_n (rst_sync_n),
        .wr_en (hit_alias[gi] && req_write),
        .slot  (slot),
        .wdata (req_wdata),
        .q     (alias_q[gi])
      );
    end
  endgenerate

  // Read mux: hits are one-hot or empty, so an OR tree suffices.
  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_PLAIN; i++) rd_mux |= hit_plain[i] ? plain_q[i] : '0;
    for (int i = 0; i < NUM_ALIAS; i++) rd_mux |= hit_alias[i] ? alias_q[i] : '0;
  end

  // Response stage: next-state then register.
  logic              rsp_valid_n;
  logic              rsp_err_n;
  logic [DATA_W-1:0] rsp_rdata_n;

  always_comb begin
    rsp_valid_n = req_valid;
    rsp_err_n   = dec_err;
    rsp_rdata_n = (req_valid && !req_write && !dec_err) ? rd_mux : '0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rsp_valid_n;
      rsp_err   <= rsp_err_n;
      rsp_rdata <= rsp_rdata_n;
    end
  end
endmodule

// File: rtl/regbank_chk.sv
module regbank_chk #(
  parameter int unsigned AW      = 15,
  parameter int unsigned NUM_HIT = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_write,
  input logic [AW-1:0]      req_addr,
  input logic [NUM_HIT-1:0] hits,
  input logic               rsp_valid,
  input logic [31:0]        rsp_rdata,
  input logic               rsp_err
);
  // R7: one register selected at most
  p_single_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hits));

  // R8: misaligned access is flagged in the next cycle
  p_misaligned_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_addr[1:0] != 2'b00)) |=> rsp_err);

  // R8, R9: an error never returns data
  p_err_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_rdata == 32'd0));

  // R10: response follows each request
  p_rsp_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R10: no spurious response
  p_no_idle_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !rsp_err));

  // R10: writes return zero
  p_write_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |=> (rsp_rdata == 32'd0));
endmodule

bind regbank_top regbank_chk #(
  .AW(AW), .NUM_HIT(NUM_PLAIN + NUM_ALIAS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_addr  (req_addr),
  .hits      ({hit_alias, hit_plain}),
  .rsp_valid (rsp_valid),
  .rsp_rdata (rsp_rdata),
  .rsp_err   (rsp_err)
);

// File: tb/regbank_top_tb.sv
module regbank_top_tb;
  localparam int NP = 4;
  localparam int NA = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [14:0] req_addr;
  logic [31:0] req_wdata;
  logic        rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;

  regbank_top u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err)
  );

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] m_plain [NP];
  logic [31:0] m_alias [NA];

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic access(input bit wr, input logic [14:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output bit er, output bit vl);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    rd = rsp_rdata; er = rsp_err; vl = rsp_valid;
  endtask

  task automatic rd_chk(input logic [14:0] a, input logic [31:0] exp, input string req);
    logic [31:0] rd; bit er, vl;
    access(1'b0, a, '0, rd, er, vl);
    chk(vl && !er && rd == exp, req, rd, exp);
  endtask

  task automatic wr_ok(input logic [14:0] a, input logic [31:0] d);
    logic [31:0] rd; bit er, vl;
    access(1'b1, a, d, rd, er, vl);
    chk(vl && !er && rd == 32'd0, "R10 write response", rd, 32'd0);
  endtask

  task automatic bad(input bit wr, input logic [14:0] a, input string req);
    logic [31:0] rd; bit er, vl;
    access(wr, a, 32'hFFFF_FFFF, rd, er, vl);
    chk(vl && er && rd == 32'd0, req, {31'd0, er}, 32'd1);
  endtask

  task automatic dump(input string req);
    for (int k = 0; k < NP; k++) rd_chk(15'(k * 4), m_plain[k], req);
    for (int g = 0; g < NA; g++) rd_chk(15'(16'h4000 + g * 16), m_alias[g], req);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] pats [4];
    pats[0] = 32'hFFFF_FFFF; pats[1] = 32'hAAAA_5555;
    pats[2] = 32'h0F0F_00F0; pats[3] = 32'h8000_0001;
    req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(!rsp_valid && !rsp_err && rsp_rdata == 0, "R1 idle outputs after reset",
        rsp_rdata, 32'd0);

    // R1: reset values, lock bit 31 on groups 0..2
    m_plain[0] = 32'h0401_167F; m_plain[1] = 32'h0000_0010;
    m_plain[2] = 32'h0001_8D00; m_plain[3] = 32'h2486_0324;
    m_alias[0] = 32'h0001_3063 | 32'h8000_0000;
    m_alias[1] = 32'h0001_2000 | 32'h8000_0000;
    m_alias[2] = 32'h0001_3001 | 32'h8000_0000;
    m_alias[3] = 32'h1018_101B;
    dump("R1 reset value");
    // R6: every slot reads the base register
    for (int g = 0; g < NA; g++)
      for (int s = 1; s < 4; s++)
        rd_chk(15'(16'h4000 + g * 16 + s * 4), m_alias[g], "R6 alias slot read");
    dump("R6 alias read leaves state");

    // R2, R7: whole-word writes to plain registers
    for (int k = 0; k < NP; k++) begin
      m_plain[k] = 32'h1357_9BDF ^ (32'h1111_1111 * k);
      wr_ok(15'(k * 4), m_plain[k]);
      dump("R7 plain write only its target");
    end
    for (int g = 0; g < NA; g++) begin
      m_alias[g] = 32'h00FF_F00F + g;
      wr_ok(15'(16'h4000 + g * 16), m_alias[g]);
    end
    dump("R2 base write replaces word");

    // R3/R4/R5 sweep over every group, slot and pattern
    for (int g = 0; g < NA; g++)
      for (int p = 0; p < 4; p++) begin
        logic [31:0] pv;
        pv = pats[p] ^ (32'h0101_0101 << g);
        m_alias[g] = m_alias[g] | pv;
        wr_ok(15'(16'h4000 + g * 16 + 4), pv);
        rd_chk(15'(16'h4000 + g * 16), m_alias[g], "R3 set slot");
        m_alias[g] = m_alias[g] & ~(pv >> 3);
        wr_ok(15'(16'h4000 + g * 16 + 8), pv >> 3);
        rd_chk(15'(16'h4000 + g * 16 + 4), m_alias[g], "R4 clear slot");
        m_alias[g] = m_alias[g] ^ (pv << 5);
        wr_ok(15'(16'h4000 + g * 16 + 12), pv << 5);
        rd_chk(15'(16'h4000 + g * 16 + 8), m_alias[g], "R5 toggle slot");
      end
    dump("R7 alias writes only their target");

    // R8: misaligned offsets over both populated ranges
    for (int w = 0; w < 4 * NA; w++)
      for (int b = 1; b < 4; b++) begin
        bad(1'b1, 15'(16'h4000 + w * 4 + b), "R8 misaligned write");
        if (w < NP) bad(1'b0, 15'(w * 4 + b), "R8 misaligned read");
      end
    dump("R8 state unchanged");

    // R9: every out-of-range word index
    for (int w = NP; w < 4096; w++) bad(w[0], 15'(w * 4), "R9 plain out of range");
    for (int w = 4 * NA; w < 4096; w++) bad(w[1], 15'(16'h4000 + w * 4), "R9 alias out of range");
    dump("R9 state unchanged");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule